// File: doc/BRIEF.md
# Variable-Block Carry-Skip Adder

A purely combinational 20-bit binary adder. It takes two operands and a carry-in and returns a 20-bit sum and a carry-out. The operand bits are cut into five ripple segments of unequal width. Inside each segment the carry moves one bit at a time through generate/propagate cells.

Each middle segment has a bypass multiplexer. When every bit of the segment propagates, the multiplexer passes the segment's incoming carry directly to the next segment and ignores the local ripple chain. The only select signal is the AND of the segment's per-bit propagate terms; no group-generate term exists. The lowest and the highest segments have no bypass and always ripple.

The segment widths are an elaboration-time parameter. The default partition is 2, 5, 6, 5, 2 bits, LSB first. This shortens the worst carry path compared with a uniform split of the same width.

Top module: `csk_adder20`

## Requirements
- R1: `sum_o` equals the low 20 bits of `a_i + b_i + carry_i` for every input combination.
- R2: `carry_o` equals bit 20 of the 21-bit result of `a_i + b_i + carry_i`.
- R3: Per-bit propagate is `a ^ b` and per-bit generate is `a & b`; within a segment, sum bit i is `p[i] ^ c[i]` and the carry advances as `g[i] | (p[i] & c[i])`.
- R4: With the default parameters, the segments occupy bits [1:0], [6:2], [12:7], [17:13] and [19:18], in that order from the least significant end.
- R5: For a middle segment whose bits all propagate, the carry handed to the next segment equals the segment's carry-in. A carry generated just below the segment therefore reaches the bits above it, and every sum bit in the segment is 0.
- R6: For a segment with at least one non-propagating bit, the carry handed onward is the ripple chain's output. That is bit HI of the sum of the operand bits below HI plus `carry_i`, where HI is the segment's upper boundary.
- R7: The first and the last segment have no bypass. Their carry-out always comes from their ripple chain.
- R8: When all 20 bits propagate (`b_i == ~a_i`), a carry-in of 1 gives `sum_o == 0` and `carry_o == 1`, and a carry-in of 0 gives `sum_o == 20'hFFFFF` and `carry_o == 0`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 20 | First operand |
| b_i | input | 20 | Second operand |
| carry_i | input | 1 | Carry into bit 0 |
| sum_o | output | 20 | Sum, low 20 bits |
| carry_o | output | 1 | Carry out of bit 19 |

## Verification
The embedded checks are immediate assertions that are evaluated whenever the inputs change. They assume all operand and carry inputs are known 0/1 values and that the inputs hold still between changes, so the combinational network has settled before it is judged.

The stimulus meets these assumptions. It changes all inputs together on the falling clock edge, only from procedural code, and compares outputs a fixed delay later. It covers:
- a dense sweep over the low operand bits, which crosses the first two segment boundaries;
- full-width and per-segment all-propagate patterns;
- walking single bits;
- a pseudo-random run.

// File: rtl/csk_pkg.sv
`timescale 1ns/1ps
package csk_pkg;
  localparam int unsigned NUM_SEG = 5;
  typedef int unsigned seg_w_t [NUM_SEG];
  localparam seg_w_t DEF_SEG_W = '{2, 5, 6, 5, 2};
endpackage

// File: rtl/csk_pg_cell.sv
`timescale 1ns/1ps
module csk_pg_cell (
  input  logic a_i,
  input  logic b_i,
  output logic p_o,
  output logic g_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
endmodule

// File: rtl/csk_ripple_seg.sv
`timescale 1ns/1ps
module csk_ripple_seg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o,
  output logic         gp_o
);
  logic [W-1:0] p, g;

  for (genvar i = 0; i < W; i++) begin : g_pg
    csk_pg_cell u_pg (.a_i(a_i[i]), .b_i(b_i[i]), .p_o(p[i]), .g_o(g[i]));
  end

  always_comb begin
    logic c;
    c = c_i;
    for (int i = 0; i < W; i++) begin
      s_o[i] = p[i] ^ c;
      c      = g[i] | (p[i] & c);
    end
    c_o = c;
  end

  assign gp_o = &p;

  // full-propagate segment: ripple output must already equal carry-in
  always_comb begin
    if (gp_o) begin
      assert_ripple_pass_R5: assert (c_o == c_i);
    end
    // R3: segment sum matches arithmetic over its own bits
    assert_seg_sum_R3: assert (s_o == W'(a_i + b_i + W'(c_i)));
  end
endmodule

// File: rtl/csk_skip_mux.sv
`timescale 1ns/1ps
module csk_skip_mux (
  input  logic c_in_i,
  input  logic c_rip_i,
  input  logic skip_i,
  output logic c_o
);
  assign c_o = skip_i ? c_in_i : c_rip_i;
endmodule

// File: rtl/csk_adder20.sv
`timescale 1ns/1ps
module csk_adder20
  import csk_pkg::*;
#(
  parameter int unsigned WIDTH = 20,
  parameter seg_w_t      SEG_W = DEF_SEG_W
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o
);
  localparam int unsigned NS = NUM_SEG;

  function automatic int unsigned seg_lo(int unsigned k);
    int unsigned acc;
    acc = 0;
    for (int unsigned j = 0; j < k; j++) acc += SEG_W[j];
    return acc;
  endfunction

  localparam int unsigned TOTAL_W = seg_lo(NS);

  logic seg_c [NS+1];
  assign seg_c[0] = carry_i;

  for (genvar k = 0; k < NS; k++) begin : g_seg
    localparam int unsigned LO = seg_lo(k);
    localparam int unsigned W  = SEG_W[k];
    localparam int unsigned HI = LO + W;

    logic rip_c, gp;

    csk_ripple_seg #(.W(W)) u_seg (
      .a_i (a_i[LO +: W]),
      .b_i (b_i[LO +: W]),
      .c_i (seg_c[k]),
      .s_o (sum_o[LO +: W]),
      .c_o (rip_c),
      .gp_o(gp)
    );

    if (k == 0 || k == NS - 1) begin : g_edge
      // R7: end segments always ripple
      assign seg_c[k+1] = rip_c;
    end else begin : g_mid
      csk_skip_mux u_mux (
        .c_in_i (seg_c[k]),
        .c_rip_i(rip_c),
        .skip_i (gp),
        .c_o    (seg_c[k+1])
      );
    end

    // boundary carry vs. arithmetic on the ports below HI
    always_comb begin
      logic [HI:0] ref_v;
      ref_v = {1'b0, a_i[HI-1:0]} + {1'b0, b_i[HI-1:0]} + (HI+1)'(carry_i);
      assert_seg_carry_R6: assert (seg_c[k+1] == ref_v[HI]);
    end
  end

  assign carry_o = seg_c[NS];

  initial begin
    assert_partition_R4: assert (TOTAL_W == WIDTH);
  end

  always_comb begin
    logic [WIDTH:0] ref_sum;
    ref_sum = {1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(carry_i);
    assert_sum_R1:   assert (sum_o == ref_sum[WIDTH-1:0]);
    assert_carry_R2: assert (carry_o == ref_sum[WIDTH]);
  end
endmodule

// File: tb/tb_csk_adder20.sv
`timescale 1ns/1ps
module tb_csk_adder20;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [19:0] a, b, s;
  logic        ci, co;
  int n_run = 0, n_fail = 0;

  csk_adder20 dut (.a_i(a), .b_i(b), .carry_i(ci), .sum_o(s), .carry_o(co));

  // R4: segment boundaries
  int seg_lo_t [5] = '{0, 2, 7, 13, 18};
  int seg_w_t  [5] = '{2, 5, 6, 5, 2};

  task automatic apply(input logic [19:0] ta, input logic [19:0] tb_v,
                       input logic tc, input string req);
    logic [20:0] exp_v;
    @(negedge clk);
    a = ta; b = tb_v; ci = tc;
    #1;
    exp_v = {1'b0, ta} + {1'b0, tb_v} + 21'(tc);
    n_run++;
    if (s !== exp_v[19:0] || co !== exp_v[20]) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h c=%0d: got sum=%h co=%0d exp sum=%h co=%0d",
               req, ta, tb_v, tc, s, co, exp_v[19:0], exp_v[20]);
    end
  endtask

  task automatic expect_val(input logic [19:0] es, input logic ec, input string req);
    n_run++;
    if (s !== es || co !== ec) begin
      n_fail++;
      $display("FAIL %s: got sum=%h co=%0d exp sum=%h co=%0d", req, s, co, es, ec);
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a = '0; b = '0; ci = 1'b0;
    // initial state: zero operands
    apply(20'h0, 20'h0, 1'b0, "R1 zero");
    expect_val(20'h0, 1'b0, "R2 zero");

    // R8 full-width propagate
    apply(20'h5A3C1, ~20'h5A3C1, 1'b1, "R8 prop cin1");
    expect_val(20'h0, 1'b1, "R8 prop cin1 exact");
    apply(20'h5A3C1, ~20'h5A3C1, 1'b0, "R8 prop cin0");
    expect_val(20'hFFFFF, 1'b0, "R8 prop cin0 exact");
    apply(20'h00000, 20'hFFFFF, 1'b1, "R8 zero/ones");

    // R5: generate just below a middle segment, segment fully propagating
    for (int k = 1; k < 4; k++) begin
      logic [19:0] m, ta, tb_v, mask;
      mask = ((20'h1 << seg_w_t[k]) - 20'h1) << seg_lo_t[k];
      m = 20'hA5A5A & mask;
      ta = m | (20'h1 << (seg_lo_t[k] - 1));
      tb_v = (~m & mask) | (20'h1 << (seg_lo_t[k] - 1));
      apply(ta, tb_v, 1'b0, "R5 skip taken");
      n_run++;
      if ((s & mask) !== 20'h0) begin
        n_fail++;
        $display("FAIL R5 seg %0d: got seg bits=%h exp 0", k, s & mask);
      end
      apply(ta, tb_v, 1'b1, "R5 skip taken cin1");
    end

    // R6: one non-propagating bit in each segment, with generate and kill
    for (int k = 0; k < 5; k++) begin
      logic [19:0] mask;
      mask = ((20'h1 << seg_w_t[k]) - 20'h1) << seg_lo_t[k];
      apply(mask, mask, 1'b0, "R6 gen all");
      apply(mask & ~(20'h1 << seg_lo_t[k]), ~mask | (20'h1 << seg_lo_t[k]), 1'b1, "R6 mixed");
      apply(20'h0, mask & ~(20'h1 << (seg_lo_t[k] + seg_w_t[k] - 1)), 1'b1, "R6 kill top");
    end

    // R7: end segments ripple (carry from bit 0 segment and into bit 19)
    apply(20'h00003, 20'h00001, 1'b0, "R7 first seg");
    apply(20'hC0000, 20'h40000, 1'b0, "R7 last seg");
    apply(20'hFFFFF, 20'h00001, 1'b0, "R7 through all");

    // R3: walking single bits
    for (int i = 0; i < 20; i++) begin
      apply(20'h1 << i, 20'h1 << i, 1'b0, "R3 walk gen");
      apply(20'h1 << i, 20'h0, 1'b1, "R3 walk prop");
    end

    // R1/R2/R4 dense sweep over low bits across first boundaries
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 16; y++) begin
        apply(20'(x), 20'(y * 17), 1'(y), "R1 sweep");
      end
    end

    // R1/R2 pseudo-random
    begin
      logic [19:0] ra, rb;
      ra = 20'h1F3A5; rb = 20'h0C6E9;
      for (int i = 0; i < 2000; i++) begin
        ra = {ra[18:0], ra[19] ^ ra[16]};
        rb = {rb[18:0], rb[19] ^ rb[16] ^ 1'b1};
        apply(ra, rb, ra[3], "R2 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule